// File: doc/BRIEF.md
# Nonvolatile Transfer Unlock Detector

This block sits beside an asynchronous-style memory bus: active-low chip enable, write enable and output enable, plus a 13-bit address. It watches for a fixed key of six consecutive read accesses. When the sixth access completes the key, it sends a one-cycle request to a separate transfer engine. That request is either a save of the working array into nonvolatile cells or a restore from them. Only the address of the sixth access decides which of the two is requested.

All bus inputs are sampled on the block clock. One access means one falling edge of chip enable, and the detector samples address and write enable on the clock that first sees chip enable low. The key is strict. A write, or a read at the wrong address, abandons the partial key and no request is issued. The access that caused the abort is then checked again as a possible first key step. While the transfer engine reports busy, the detector is held in its idle state. A store-inhibit input from the supply monitor suppresses save requests. Restore requests are not affected by it.

The state machine has six states. `ST_IDLE` means no key step has matched. `ST_K1` to `ST_K5` mean that many steps have matched. The transitions are:
- **advance**: a read at the expected address moves to the next state.
- **restart**: a mismatching access that is a read of 0x0000 goes to `ST_K1`.
- **abort**: any other mismatch, and every write, goes to `ST_IDLE`.
- **fire**: any access in `ST_K5` ends the key and returns to `ST_IDLE`. A read at a request address issues that request.
- **hold**: busy forces `ST_IDLE`.

Top module: `nv_unlock_detector`

## Requirements
- R1: The first five accesses of the key must be reads (we_n = 1) at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order.
- R2: A sixth read at 0x0F0F produces one store_req pulse. A sixth read at 0x0F0E produces one recall_req pulse. Any other sixth address produces neither.
- R3: A write (we_n = 0) at any key position, or a read at a wrong address, aborts the key. No request follows from the rest of that key.
- R4: The level of oe_n has no effect on key recognition.
- R5: Only a falling edge of ce_n is an access. Address changes while ce_n stays low are ignored. The request pulse is high in the clock cycle after the clock edge that first samples ce_n low on the sixth access.
- R6: While store_inhibit is 1 at the sixth access, no store_req is issued. A recall is still issued under inhibit.
- R7: After an abort caused by a read of 0x0000, that read counts as the first step of a new key.
- R8: While busy is 1, the detector returns to idle and issues no request. A key interrupted by busy must be started again.
- R9: store_req and recall_req are never high together, and each pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Bus chip enable, active low; its falling edge marks one access |
| we_n | input | 1 | Bus write enable, active low; high means the access is a read |
| oe_n | input | 1 | Bus output enable, active low; not used for recognition |
| addr | input | 13 | Bus address |
| busy | input | 1 | Transfer engine active; holds the detector idle |
| store_inhibit | input | 1 | Supply below switch level; blocks save requests |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle restore request |

## Verification
Two functions can fall on the same clock edge. The first is completion of the key at the sixth access. The second is a blocking input, either busy or store_inhibit. The bench raises busy so that it overlaps the sixth falling edge, and separately raises store_inhibit at the sixth access for both request addresses. It then judges the outcome by counting request pulses at the ports. A sweep over 32 candidate final addresses, with the expected request computed from the address, checks that exactly one pulse of the correct kind appears. A direct check of the pulse at the exact cycle after the sampling edge confirms the one-cycle latency.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
    // Number of prefix steps before the deciding access
    localparam int NPRE  = 5;
    localparam int POS_W = $clog2(NPRE + 1);

    // Encoding equals the count of matched key steps
    typedef enum logic [POS_W-1:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_K3   = 3'd3,
        ST_K4   = 3'd4,
        ST_K5   = 3'd5
    } nvu_state_e;
endpackage

// File: rtl/nvu_access_sampler.sv
module nvu_access_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic acc_valid,
    output logic acc_read
);
    logic ce_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_n_q <= 1'b1;
        else        ce_n_q <= ce_n;
    end

    // A step is the first clock that sees chip enable low
    assign acc_valid = ce_n_q & ~ce_n;
    assign acc_read  = we_n;

    // R5
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid);
endmodule

// File: rtl/nvu_key_match.sv
module nvu_key_match #(
    parameter int ADDR_W = 13,
    parameter int NPRE   = 5,
    parameter int POS_W  = 3,
    parameter logic [NPRE-1:0][ADDR_W-1:0] PREFIX = '0,
    parameter logic [ADDR_W-1:0] STORE_KEY  = '0,
    parameter logic [ADDR_W-1:0] RECALL_KEY = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [POS_W-1:0]  pos,
    output logic              prefix_hit,
    output logic              first_hit,
    output logic              store_hit,
    output logic              recall_hit
);
    logic [NPRE-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NPRE; g++) begin : g_cmp
            assign hit[g] = (addr == PREFIX[g]);
        end
    endgenerate

    always_comb begin
        prefix_hit = 1'b0;
        for (int i = 0; i < NPRE; i++) begin
            if (pos == POS_W'(i)) prefix_hit = hit[i];
        end
    end

    assign first_hit  = hit[0];
    assign store_hit  = (addr == STORE_KEY);
    assign recall_hit = (addr == RECALL_KEY);
endmodule

// File: rtl/nv_unlock_detector.sv
module nv_unlock_detector
    import nvu_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-1:0] KEY_A = 13'h0000,
    parameter logic [ADDR_W-1:0] KEY_B = 13'h1555,
    parameter logic [ADDR_W-1:0] KEY_C = 13'h0AAA,
    parameter logic [ADDR_W-1:0] KEY_D = 13'h1FFF,
    parameter logic [ADDR_W-1:0] KEY_E = 13'h10F0,
    parameter logic [ADDR_W-1:0] KEY_STORE  = 13'h0F0F,
    parameter logic [ADDR_W-1:0] KEY_RECALL = 13'h0F0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              store_inhibit,
    output logic              store_req,
    output logic              recall_req
);
    localparam logic [NPRE-1:0][ADDR_W-1:0] PREFIX_KEYS =
        {KEY_E, KEY_D, KEY_C, KEY_B, KEY_A};

    // Output enable plays no part in recognition
    logic oe_unused;
    assign oe_unused = oe_n;

    logic acc_valid, acc_read;
    logic prefix_hit, first_hit, store_hit, recall_hit;
    nvu_state_e state, state_nx;
    logic fire_store, fire_recall;

    nvu_access_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .acc_valid (acc_valid),
        .acc_read  (acc_read)
    );

    nvu_key_match #(
        .ADDR_W     (ADDR_W),
        .NPRE       (NPRE),
        .POS_W      (POS_W),
        .PREFIX     (PREFIX_KEYS),
        .STORE_KEY  (KEY_STORE),
        .RECALL_KEY (KEY_RECALL)
    ) u_match (
        .addr       (addr),
        .pos        (state),
        .prefix_hit (prefix_hit),
        .first_hit  (first_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    always_comb begin
        state_nx    = state;
        fire_store  = 1'b0;
        fire_recall = 1'b0;
        if (busy) begin
            state_nx = ST_IDLE;
        end else if (acc_valid) begin
            if (!acc_read) begin
                state_nx = ST_IDLE;
            end else begin
                unique case (state)
                    ST_K5: begin
                        fire_store  = store_hit & ~store_inhibit;
                        fire_recall = recall_hit;
                        if (!store_hit && !recall_hit && first_hit) state_nx = ST_K1;
                        else                                        state_nx = ST_IDLE;
                    end
                    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4: begin
                        if (prefix_hit)     state_nx = nvu_state_e'(state + 3'd1);
                        else if (first_hit) state_nx = ST_K1;
                        else                state_nx = ST_IDLE;
                    end
                    default: state_nx = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            store_req  <= fire_store;
            recall_req <= fire_recall;
        end
    end

    // R9
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));
    // R9
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);
    // R9
    recall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);
    // R6
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> !$past(store_inhibit));
    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!store_req && !recall_req && state == ST_IDLE));
    // R5
    req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> (!$past(ce_n) && $past(ce_n, 2)));
    // R3
    req_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(we_n));
    // R2
    req_from_k5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> $past(state) == ST_K5);
endmodule

// File: tb/nv_unlock_detector_tb_top.sv
module nv_unlock_detector_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic busy = 1'b0, inh = 1'b0;
    logic store_req, recall_req;

    int total = 0, bad = 0;
    int n_st = 0, n_rc = 0, n_both = 0;

    localparam logic [12:0] K0 = 13'h0000, K1 = 13'h1555, K2 = 13'h0AAA,
                            K3 = 13'h1FFF, K4 = 13'h10F0;
    localparam logic [12:0] KS = 13'h0F0F, KR = 13'h0F0E;

    always #(CLK_P/2) clk = ~clk;

    nv_unlock_detector dut_i (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .busy (busy), .store_inhibit (inh),
        .store_req (store_req), .recall_req (recall_req)
    );

    always @(negedge clk) begin
        if (store_req)  n_st++;
        if (recall_req) n_rc++;
        if (store_req && recall_req) n_both++;
    end

    function automatic logic [12:0] key(input int k);
        case (k)
            0: key = K0; 1: key = K1; 2: key = K2; 3: key = K3;
            default: key = K4;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic acc(input logic [12:0] a, input logic w, input logic o);
        @(negedge clk); addr = a; we_n = w; oe_n = o; ce_n = 1'b0;
        @(negedge clk);
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prefix(input int n);
        for (int k = 0; k < n; k++) acc(key(k), 1'b1, 1'b0);
    endtask

    task automatic clr();
        n_st = 0; n_rc = 0;
    endtask

    task automatic expect_ops(input int es, input int er, input string req);
        chk(n_st == es, req, n_st, es);
        chk(n_rc == er, req, n_rc, er);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(store_req == 0 && recall_req == 0, "reset", int'({store_req, recall_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: both request kinds
        clr(); prefix(5); acc(KS, 1'b1, 1'b0); expect_ops(1, 0, "R1 R2 store");
        clr(); prefix(5); acc(KR, 1'b1, 1'b0); expect_ops(0, 1, "R1 R2 recall");

        // R2: sweep of the deciding address
        for (int v = 0; v < 32; v++) begin
            clr(); prefix(5); acc(13'h0F00 + 13'(v), 1'b1, 1'b0);
            expect_ops((v == 15) ? 1 : 0, (v == 14) ? 1 : 0, "R2 sweep");
        end

        // R3: wrong address at each prefix position
        for (int k = 0; k < 5; k++) begin
            clr(); prefix(k); acc(key(k) ^ 13'h0100, 1'b1, 1'b0);
            for (int j = k + 1; j < 5; j++) acc(key(j), 1'b1, 1'b0);
            acc(KS, 1'b1, 1'b0);
            expect_ops(0, 0, "R3 wrong addr");
        end

        // R3: write at each of six positions with the right address
        for (int k = 0; k < 6; k++) begin
            clr(); prefix(k);
            acc((k < 5) ? key(k) : KS, 1'b0, 1'b0);
            for (int j = k + 1; j < 5; j++) acc(key(j), 1'b1, 1'b0);
            if (k < 5) acc(KS, 1'b1, 1'b0);
            expect_ops(0, 0, "R3 write");
        end

        // R4: oe_n high and toggling
        clr();
        for (int k = 0; k < 5; k++) acc(key(k), 1'b1, 1'b1);
        acc(KR, 1'b1, 1'b1); expect_ops(0, 1, "R4 oe high");
        clr();
        for (int k = 0; k < 5; k++) acc(key(k), 1'b1, 1'(k % 2));
        acc(KS, 1'b1, 1'b0); expect_ops(1, 0, "R4 oe mixed");

        // R5: address walk while ce_n held low counts once
        clr();
        @(negedge clk); we_n = 1'b1; addr = K0; ce_n = 1'b0;
        for (int k = 1; k < 5; k++) begin @(negedge clk); addr = key(k); end
        @(negedge clk); addr = KS;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
        for (int k = 1; k < 5; k++) acc(key(k), 1'b1, 1'b0);
        acc(KS, 1'b1, 1'b0); expect_ops(1, 0, "R5 held low");

        // R5: latency of the pulse
        clr(); prefix(5);
        @(negedge clk); addr = KS; we_n = 1'b1; ce_n = 1'b0;
        chk(store_req == 0, "R5 before edge", store_req, 0);
        @(negedge clk); chk(store_req == 1, "R5 pulse cycle", store_req, 1);
        @(negedge clk); chk(store_req == 0, "R5 pulse end", store_req, 0);
        ce_n = 1'b1; @(negedge clk);

        // R6: inhibit
        clr(); prefix(5); inh = 1'b1; acc(KS, 1'b1, 1'b0); inh = 1'b0;
        expect_ops(0, 0, "R6 store inhibited");
        clr(); prefix(5); inh = 1'b1; acc(KR, 1'b1, 1'b0); inh = 1'b0;
        expect_ops(0, 1, "R6 recall allowed");

        // R7: restart on 0x0000
        clr(); prefix(3); prefix(5); acc(KS, 1'b1, 1'b0);
        expect_ops(1, 0, "R7 restart");
        clr(); prefix(5); acc(K0, 1'b1, 1'b0);
        for (int k = 1; k < 5; k++) acc(key(k), 1'b1, 1'b0);
        acc(KR, 1'b1, 1'b0); expect_ops(0, 1, "R7 restart at sixth");

        // R8: busy mid key and at the deciding access
        clr(); prefix(2); busy = 1'b1; acc(K2, 1'b1, 1'b0); busy = 1'b0;
        acc(K3, 1'b1, 1'b0); acc(K4, 1'b1, 1'b0); acc(KS, 1'b1, 1'b0);
        expect_ops(0, 0, "R8 busy mid");
        clr(); prefix(5); busy = 1'b1; acc(KR, 1'b1, 1'b0); busy = 1'b0;
        expect_ops(0, 0, "R8 busy sixth");
        clr(); prefix(5); acc(KS, 1'b1, 1'b0); expect_ops(1, 0, "R8 recovery");

        // R9: never together over the whole run
        chk(n_both == 0, "R9 exclusive", n_both, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule